// File: doc/BRIEF.md
# Load/Store Data Size Aligner

This block sits between a register file and a byte-addressed, little-endian memory port that is 32 bits wide. It handles transfers of a whole word, a halfword or a single byte. A load request carries the full word read from memory. The block picks out the byte or halfword that the low address bits point at and widens it to 32 bits. The widening is with zeros when the access is unsigned and with copies of the top bit when it is signed. A store request carries register data. The block copies the low byte or halfword into every lane it could land in and produces a 4-bit byte-enable that marks the lanes memory must write. A word or halfword at an address that does not suit its size is flagged, and nothing is enabled for it.

Requests enter on a valid/ready stream, and results leave on a second valid/ready stream through one output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so a stream of back-to-back requests runs at one per clock. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted.

Top module: `ls_size_aligner`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every result output holds its value into the next cycle. An accepted request shows up with `out_valid` high on the clock edge after the one that accepted it.
- R2: A word load (`in_size` 2'b10, or 2'b11 treated the same) at address bits 2'b00 returns `in_rdata` unchanged. Byte k of memory sits in bits [8k+7:8k], so bytes aa, bb, cc, dd at offsets 0 to 3 read as 0xddccbbaa.
- R3: A byte load (`in_size` 2'b00) returns bits [8k+7:8k] of `in_rdata` in bits [7:0], where k is the value of `in_addr_lo`.
- R4: A halfword load (`in_size` 2'b01) returns `in_rdata[15:0]` when `in_addr_lo[1]` is 0 and `in_rdata[31:16]` when it is 1.
- R5: With `in_signed` high, byte and halfword loads fill the upper bits with the top bit of the selected data. With `in_signed` low, they fill the upper bits with zeros. A word load is not changed by `in_signed`.
- R6: A store puts on `out_wdata` the word unchanged, the low halfword in both halves, or the low byte in all four lanes, according to the size.
- R7: A store's `out_be` is 4'b1111 for a word. For a halfword it is 4'b0011 at offset 0 and 4'b1100 at offset 2. For a byte it is the one-hot value 1 shifted left by `in_addr_lo`.
- R8: A halfword with `in_addr_lo[0]` set, or a word with `in_addr_lo` not 2'b00, sets `out_misalign`. It also forces `out_be`, `out_wdata` and `out_ldata` to zero. A byte access is never misaligned.
- R9: `in_signed` has no effect on any output of a store.
- R10: A load drives `out_be` and `out_wdata` to zero. A store drives `out_ldata` to zero. After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| in_signed | input | 1 | Sign-extend narrow loads |
| in_addr_lo | input | 2 | Low byte-address bits |
| in_wdata | input | 32 | Register data for a store |
| in_rdata | input | 32 | Word read from memory for a load |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ldata | output | 32 | Aligned and extended load data |
| out_wdata | output | 32 | Lane-replicated store data |
| out_be | output | 4 | Store byte enables |
| out_misalign | output | 1 | Access does not suit its address |

## Verification
The aligner has no internal state apart from the output register. A wrong lane select, a wrong extension, or a wrong enable pattern therefore shows up in the result one clock after the request is accepted. The vector table covers every lane offset for each size. It also includes narrow data whose top bit is set and whose top bit is clear. A stall defect would appear as a result that changes, or a request that is lost, while `out_ready` is held low. The directed stall test observes exactly that window, cycle by cycle.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  function automatic logic is_word(input logic [1:0] sz);
    return sz[1];
  endfunction
endpackage

// File: rtl/ls_lane_check.sv
module ls_lane_check
  import ls_align_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LB    = $clog2(LANES)
) (
  input  logic [1:0]    size,
  input  logic [LB-1:0] addr,
  output logic [LANES-1:0] be,
  output logic          misalign
);
  always_comb begin
    misalign = 1'b0;
    if (is_word(size))          misalign = (addr != '0);
    else if (size == SZ_HALF)   misalign = addr[0];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [LB-1:0] KIDX = LB'(k);
    always_comb begin
      if (is_word(size))        be[k] = 1'b1;
      else if (size == SZ_HALF) be[k] = (KIDX[LB-1:1] == addr[LB-1:1]);
      else                      be[k] = (KIDX == addr);
    end
  end
endmodule

// File: rtl/ls_store_replicate.sv
module ls_store_replicate
  import ls_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] lanes_out
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (is_word(size))        lanes_out[8*k +: 8] = src[8*k +: 8];
      else if (size == SZ_HALF) lanes_out[8*k +: 8] = src[8*(k%2) +: 8];
      else                      lanes_out[8*k +: 8] = src[7:0];
    end
  end
endmodule

// File: rtl/ls_load_extract.sv
module ls_load_extract
  import ls_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LB     = $clog2(DATA_W / 8)
) (
  input  logic [1:0]        size,
  input  logic              sgn,
  input  logic [LB-1:0]     addr,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] data_out
);
  logic [7:0]  pick_b;
  logic [15:0] pick_h;
  logic [LB-1:0] half_sel;

  always_comb begin
    half_sel = {addr[LB-1:1], 1'b0};
    pick_b   = word_in[{addr, 3'b000} +: 8];
    pick_h   = word_in[{half_sel, 3'b000} +: 16];
    if (is_word(size))
      data_out = word_in;
    else if (size == SZ_HALF)
      data_out = {{(DATA_W-16){sgn & pick_h[15]}}, pick_h};
    else
      data_out = {{(DATA_W-8){sgn & pick_b[7]}}, pick_b};
  end
endmodule

// File: rtl/ls_size_aligner.sv
module ls_size_aligner
  import ls_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LB     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_store,
  input  logic [1:0]        in_size,
  input  logic              in_signed,
  input  logic [LB-1:0]     in_addr_lo,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] in_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_ldata,
  output logic [DATA_W-1:0] out_wdata,
  output logic [LANES-1:0]  out_be,
  output logic              out_misalign
);
  logic [LANES-1:0]  be_raw;
  logic              mis_raw;
  logic [DATA_W-1:0] rep_raw, ld_raw;
  logic [DATA_W-1:0] nx_ldata, nx_wdata;
  logic [LANES-1:0]  nx_be;
  logic              accept;
  logic              q_store, q_signed;
  logic [1:0]        q_size;

  ls_lane_check #(.LANES(LANES), .LB(LB)) u_check (
    .size(in_size), .addr(in_addr_lo), .be(be_raw), .misalign(mis_raw)
  );

  ls_store_replicate #(.DATA_W(DATA_W), .LANES(LANES)) u_rep (
    .size(in_size), .src(in_wdata), .lanes_out(rep_raw)
  );

  ls_load_extract #(.DATA_W(DATA_W), .LB(LB)) u_ext (
    .size(in_size), .sgn(in_signed), .addr(in_addr_lo),
    .word_in(in_rdata), .data_out(ld_raw)
  );

  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
    nx_be    = (in_is_store && !mis_raw) ? be_raw  : '0;
    nx_wdata = (in_is_store && !mis_raw) ? rep_raw : '0;
    nx_ldata = (!in_is_store && !mis_raw) ? ld_raw : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_ldata    <= '0;
      out_wdata    <= '0;
      out_be       <= '0;
      out_misalign <= 1'b0;
      q_store      <= 1'b0;
      q_signed     <= 1'b0;
      q_size       <= 2'b00;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_ldata    <= nx_ldata;
      out_wdata    <= nx_wdata;
      out_be       <= nx_be;
      out_misalign <= mis_raw;
      q_store      <= in_is_store;
      q_signed     <= in_signed;
      q_size       <= in_size;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ldata) && $stable(out_wdata)
      && $stable(out_be) && $stable(out_misalign))); // R1

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_store && q_size == SZ_BYTE) |-> ($countones(out_be) == 1)); // R7

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_misalign) |-> (out_be == '0 && out_ldata == '0 && out_wdata == '0)); // R8

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !q_store) |-> (out_be == '0 && out_wdata == '0)); // R10

  AST_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !q_store && q_size == SZ_BYTE && !out_misalign)
      |-> (out_ldata[DATA_W-1:8] == {(DATA_W-8){q_signed & out_ldata[7]}})); // R5

  AST_HALF_NEVER_ODD_BE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_store && q_size == SZ_HALF && !out_misalign)
      |-> ($countones(out_be) == 2)); // R7
endmodule

// File: tb/tb_ls_size_aligner.sv
module tb_ls_size_aligner;
  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        sg;
    logic [1:0]  a;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [31:0] eld;
    logic [31:0] ewd;
    logic [3:0]  ebe;
    logic        emis;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam logic [31:0] RA = 32'hddccbbaa;
  localparam logic [31:0] RB = 32'h80ff7f01;
  localparam vec_t VECS [NV] = '{
    '{1'b0,2'd2,1'b0,2'd0,32'h0,RA,RA,32'h0,4'h0,1'b0,4'd2},            // R2 word load
    '{1'b0,2'd3,1'b0,2'd0,32'h0,RA,RA,32'h0,4'h0,1'b0,4'd2},            // R2 size 11 as word
    '{1'b0,2'd0,1'b0,2'd0,32'h0,RA,32'h000000aa,32'h0,4'h0,1'b0,4'd3},  // R3
    '{1'b0,2'd0,1'b0,2'd1,32'h0,RA,32'h000000bb,32'h0,4'h0,1'b0,4'd3},  // R3
    '{1'b0,2'd0,1'b0,2'd2,32'h0,RA,32'h000000cc,32'h0,4'h0,1'b0,4'd3},  // R3
    '{1'b0,2'd0,1'b0,2'd3,32'h0,RA,32'h000000dd,32'h0,4'h0,1'b0,4'd3},  // R3
    '{1'b0,2'd0,1'b1,2'd3,32'h0,RA,32'hffffffdd,32'h0,4'h0,1'b0,4'd5},  // R5
    '{1'b0,2'd0,1'b1,2'd0,32'h0,RA,32'hffffffaa,32'h0,4'h0,1'b0,4'd5},  // R5
    '{1'b0,2'd1,1'b0,2'd0,32'h0,RA,32'h0000bbaa,32'h0,4'h0,1'b0,4'd4},  // R4
    '{1'b0,2'd1,1'b0,2'd2,32'h0,RA,32'h0000ddcc,32'h0,4'h0,1'b0,4'd4},  // R4
    '{1'b0,2'd1,1'b1,2'd2,32'h0,RA,32'hffffddcc,32'h0,4'h0,1'b0,4'd5},  // R5
    '{1'b0,2'd0,1'b1,2'd1,32'h0,RB,32'h0000007f,32'h0,4'h0,1'b0,4'd5},  // R5 positive byte
    '{1'b0,2'd0,1'b1,2'd2,32'h0,RB,32'hffffffff,32'h0,4'h0,1'b0,4'd5},  // R5
    '{1'b0,2'd0,1'b0,2'd3,32'h0,RB,32'h00000080,32'h0,4'h0,1'b0,4'd5},  // R5 unsigned
    '{1'b0,2'd1,1'b1,2'd0,32'h0,RB,32'h00007f01,32'h0,4'h0,1'b0,4'd5},  // R5 positive half
    '{1'b0,2'd1,1'b1,2'd2,32'h0,RB,32'hffff80ff,32'h0,4'h0,1'b0,4'd5},  // R5
    '{1'b0,2'd2,1'b1,2'd0,32'h0,RB,RB,32'h0,4'h0,1'b0,4'd5},            // R5 word untouched
    '{1'b1,2'd2,1'b0,2'd0,RA,32'h0,32'h0,RA,4'hf,1'b0,4'd6},            // R6 word store
    '{1'b1,2'd1,1'b0,2'd0,RA,32'h0,32'h0,32'hbbaabbaa,4'h3,1'b0,4'd7},  // R7
    '{1'b1,2'd1,1'b0,2'd2,RA,32'h0,32'h0,32'hbbaabbaa,4'hc,1'b0,4'd7},  // R7
    '{1'b1,2'd0,1'b0,2'd0,RA,32'h0,32'h0,32'haaaaaaaa,4'h1,1'b0,4'd6},  // R6
    '{1'b1,2'd0,1'b0,2'd1,RA,32'h0,32'h0,32'haaaaaaaa,4'h2,1'b0,4'd7},  // R7
    '{1'b1,2'd0,1'b0,2'd2,RA,32'h0,32'h0,32'haaaaaaaa,4'h4,1'b0,4'd7},  // R7
    '{1'b1,2'd0,1'b0,2'd3,RA,32'h0,32'h0,32'haaaaaaaa,4'h8,1'b0,4'd7},  // R7
    '{1'b1,2'd0,1'b1,2'd2,RA,32'h0,32'h0,32'haaaaaaaa,4'h4,1'b0,4'd9},  // R9
    '{1'b1,2'd1,1'b1,2'd2,RA,32'h0,32'h0,32'hbbaabbaa,4'hc,1'b0,4'd9},  // R9
    '{1'b1,2'd0,1'b1,2'd1,32'h000000f0,32'h0,32'h0,32'hf0f0f0f0,4'h2,1'b0,4'd9}, // R9
    '{1'b0,2'd2,1'b0,2'd1,32'h0,RA,32'h0,32'h0,4'h0,1'b1,4'd8},         // R8
    '{1'b0,2'd1,1'b1,2'd1,32'h0,RA,32'h0,32'h0,4'h0,1'b1,4'd8},         // R8
    '{1'b0,2'd1,1'b0,2'd3,32'h0,RA,32'h0,32'h0,4'h0,1'b1,4'd8},         // R8
    '{1'b1,2'd2,1'b0,2'd2,RA,32'h0,32'h0,32'h0,4'h0,1'b1,4'd8},         // R8
    '{1'b1,2'd1,1'b0,2'd1,RA,32'h0,32'h0,32'h0,4'h0,1'b1,4'd8},         // R8
    '{1'b1,2'd0,1'b0,2'd3,32'h12345678,RA,32'h0,32'h78787878,4'h8,1'b0,4'd10} // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_is_store = 1'b0, in_signed = 1'b0;
  logic [1:0] in_size = 2'b00, in_addr_lo = 2'b00;
  logic [31:0] in_wdata = '0, in_rdata = '0;
  logic out_valid, out_ready = 1'b1, out_misalign;
  logic [31:0] out_ldata, out_wdata;
  logic [3:0] out_be;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ls_size_aligner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_store(in_is_store), .in_size(in_size), .in_signed(in_signed),
    .in_addr_lo(in_addr_lo), .in_wdata(in_wdata), .in_rdata(in_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_ldata(out_ldata),
    .out_wdata(out_wdata), .out_be(out_be), .out_misalign(out_misalign)
  );

  task automatic check(input bit ok, input string req, input logic [103:0] act,
                       input logic [103:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_is_store = v.st; in_size = v.sz; in_signed = v.sg; in_addr_lo = v.a;
    in_wdata = v.wd; in_rdata = v.rd;
  endtask

  function automatic logic [103:0] packed_out();
    return {3'b0, out_valid, out_ldata, out_wdata, out_be, out_misalign, 3'b0};
  endfunction

  function automatic logic [103:0] packed_exp(input vec_t v);
    return {3'b0, 1'b1, v.eld, v.ewd, v.ebe, v.emis, 3'b0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [103:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10",
          {102'b0, out_valid, in_ready}, 104'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(packed_out() == packed_exp(VECS[i]), $sformatf("R%0d vec%0d", VECS[i].req, i),
            packed_out(), packed_exp(VECS[i]));
      @(negedge clk);
    end

    // R1 back-to-back: one result per clock
    for (int i = 2; i < 6; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      check(packed_out() == packed_exp(VECS[i]) && in_ready, "R1 streaming",
            packed_out(), packed_exp(VECS[i]));
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R1 stall: result held, new request blocked
    out_ready = 1'b0;
    drive(VECS[19]);
    in_valid = 1'b1;
    @(negedge clk);
    held = packed_out();
    check(held == packed_exp(VECS[19]) && !in_ready, "R1 stall capture", held,
          packed_exp(VECS[19]));
    drive(VECS[6]);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(packed_out() == held && !in_ready, "R1 stall hold", packed_out(), held);
    end
    out_ready = 1'b1;
    // pending request is taken on this edge since out_ready opens in_ready
    @(negedge clk);
    in_valid = 1'b0;
    check(packed_out() == packed_exp(VECS[6]), "R1 release", packed_out(),
          packed_exp(VECS[6]));
    @(negedge clk);
    check(out_valid == 1'b0, "R1 drain", {103'b0, out_valid}, 104'h0);

    // R10 reset mid-run clears valid
    drive(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0 && out_be == 4'h0 && in_ready, "R10 reset",
          {99'b0, out_valid, out_be}, 104'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule